// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge

This block lets a clocked host read and write an external asynchronous static RAM of 256K sixteen-bit words. The RAM has an active-low and an active-high chip select, an active-low output enable, an active-low write strobe and one active-low enable per byte lane. The host presents a request: a word address, write data, a per-lane byte mask and a write flag. It holds the request until the bridge returns a one-cycle acknowledge. For reads, the bridge returns the data with a one-cycle valid pulse in the same cycle as the acknowledge.

Each asynchronous limit of the RAM is a parameter in picoseconds. These are address and chip-select access time, output-enable access time, minimum cycle times, write-pulse width, address-to-end-of-write, data-to-end-of-write overlap and output release time. Each limit is turned into a clock-cycle count by ceiling division against a clock-period parameter. The pins come straight from registers, so they do not glitch. The data bus is split into an output word, an output enable for the bridge's own drivers, and an input word, which the pad ring combines.

A sequencer drives the access and uses these states:
- `ST_IDLE`: waiting for a request.
- `ST_RD_ACT`: reading, with the RAM driving the bus.
- `ST_RD_REL`: waiting after a read while the RAM lets go of the bus.
- `ST_WR_SET`: write setup.
- `ST_WR_PULSE`: write strobe low.
- `ST_WR_HOLD`: write hold.
- `ST_DONE`: acknowledge.

It makes these transitions:
- `ST_IDLE` → `ST_RD_ACT` on a read request with a non-empty mask.
- `ST_IDLE` → `ST_WR_SET` on a write request with a non-empty mask.
- `ST_IDLE` → `ST_DONE` on any request with an empty mask.
- `ST_RD_ACT` → `ST_RD_REL` when the read count expires.
- `ST_RD_REL` → `ST_DONE` when the release count expires.
- `ST_WR_SET` → `ST_WR_PULSE` after one cycle.
- `ST_WR_PULSE` → `ST_WR_HOLD` when the pulse count expires.
- `ST_WR_HOLD` → `ST_DONE` after one cycle.
- `ST_DONE` → `ST_IDLE` after one cycle.

Top module: `sram_bridge`

## Requirements
- R1: While reset is held and after it, before any request: mem_sel_n=1, mem_sel=0, mem_oe_n=1, mem_we_n=1, mem_lo_n=1, mem_hi_n=1, mem_dq_drv=0, req_ack=0, rd_valid=0.
- R2: Phase lengths are ceiling divisions of the timing parameters by CLK_PS. Read phase: the largest of the read-cycle, address-access and output-enable limits (10 cycles by default). Write pulse: the largest of the pulse-width, address-to-end, data-overlap limits and the write-cycle count less two (8 by default). Release gap: the output release limit (3 by default). With defaults, req_ack rises 10 cycles after the accepting edge for a write and 13 for a read.
- R3: A read with a non-empty mask holds mem_sel_n=0, mem_sel=1, mem_we_n=1 and mem_oe_n=0 for the whole read phase. Mask bit 0 selects lane bits [7:0] (mem_lo_n=0) and mask bit 1 selects bits [15:8] (mem_hi_n=0). rd_data is the bus value sampled in the last cycle of that phase.
- R4: On a read, the rd_data lanes whose mask bit is 0 are returned as zero, whatever the bus carries.
- R5: A write with a non-empty mask has one setup cycle, then mem_we_n low for exactly the write-pulse count, then one hold cycle. The chip is selected and the bridge drives mem_dq_o throughout. mem_we_n is never low without the chip selected. Only lanes whose mask bit is 1 are written.
- R6: While the chip stays selected, mem_a, mem_lo_n, mem_hi_n and the driven mem_dq_o do not change.
- R7: mem_dq_drv is never 1 while mem_oe_n=0. After mem_oe_n rises, mem_dq_drv stays 0 for at least the release-gap count of cycles.
- R8: A request with mask 00 never selects the chip. It is acknowledged in the cycle after acceptance without rd_valid, and the RAM contents are unchanged.
- R9: req_ack is high for single cycles only. rd_valid is high only together with req_ack, and only for reads with a non-empty mask.
- R10: Request fields are captured at the accepting edge. Changes to them while the access is in progress have no effect on the pins or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Lane mask, bit 0 = bits [7:0], bit 1 = bits [15:8] |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data valid, with req_ack |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_a | output | 18 | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lo_n | output | 1 | Low-lane enable, active low |
| mem_hi_n | output | 1 | High-lane enable, active low |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_drv | output | 1 | Enable for the bridge's data drivers |
| mem_dq_i | input | 16 | Data from the RAM |

## Verification
Two events can fall in the same cycle: the end of one access, with its release gap, and the start of the next access on the shared bus. The bench provokes this by issuing a write immediately after each read completes, so the write's setup cycle comes as early as the sequencer permits. Every clock, the bench checks that the bridge's drivers stay off while the output enable is low and for the whole release window after it rises. A RAM model in the bench latches writes on the rising strobe, and read-back against an independent expected memory shows whether any lane was corrupted at the turnaround.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACT,
        ST_RD_REL,
        ST_WR_SET,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_DONE
    } seq_state_t;

    // Ceiling division of a time limit by the clock period
    function automatic int unsigned to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              sel_nxt,
    input  logic              capture,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  en_n,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic              be_r;
        logic              en_r;
        logic [LANE_W-1:0] wd_r;
        logic [LANE_W-1:0] rd_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                be_r <= 1'b0;
                en_r <= 1'b1;
                wd_r <= '0;
                rd_r <= '0;
            end else begin
                if (accept) begin
                    be_r <= req_be[i];
                    wd_r <= req_wdata[i*LANE_W +: LANE_W];
                end
                en_r <= !(sel_nxt && (accept ? req_be[i] : be_r));
                if (capture) begin
                    rd_r <= be_r ? dq_in[i*LANE_W +: LANE_W] : '0;
                end
            end
        end

        assign en_n[i]                    = en_r;
        assign dq_out[i*LANE_W +: LANE_W] = wd_r;
        assign rdata[i*LANE_W +: LANE_W]  = rd_r;
    end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_bridge_pkg::*;
#(
    parameter int unsigned RD_CYC   = 10,
    parameter int unsigned WR_CYC   = 8,
    parameter int unsigned TURN_CYC = 3,
    parameter int unsigned CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_mask_zero,
    input  logic             timer_last,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output logic             sel_nxt,
    output logic             cs_on,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe,
    output logic             ack,
    output logic             rd_valid
);

    seq_state_t state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mask_zero)  state_d = ST_DONE;
                    else if (req_write) state_d = ST_WR_SET;
                    else                state_d = ST_RD_ACT;
                end
            end
            ST_RD_ACT:   if (timer_last) state_d = ST_RD_REL;
            ST_RD_REL:   if (timer_last) state_d = ST_DONE;
            ST_WR_SET:   state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (timer_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        timer_load = (state_d != state_q);
        unique case (state_d)
            ST_RD_ACT:   timer_val = CNT_W'(RD_CYC - 1);
            ST_RD_REL:   timer_val = CNT_W'(TURN_CYC - 1);
            ST_WR_PULSE: timer_val = CNT_W'(WR_CYC - 1);
            default:     timer_val = '0;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_ACT) && timer_last;
    assign sel_nxt = (state_d == ST_RD_ACT) || (state_d == ST_WR_SET) ||
                     (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_on    <= 1'b0;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            dq_oe    <= 1'b0;
            ack      <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            cs_on    <= sel_nxt;
            oe_n     <= (state_d != ST_RD_ACT);
            we_n     <= (state_d != ST_WR_PULSE);
            dq_oe    <= (state_d == ST_WR_SET) || (state_d == ST_WR_PULSE) ||
                        (state_d == ST_WR_HOLD);
            ack      <= (state_d == ST_DONE);
            rd_valid <= (state_d == ST_DONE) && (state_q == ST_RD_REL);
        end
    end

    // Observers for the protocol properties
    logic [CNT_W-1:0] rel_cnt;
    logic [CNT_W:0]   we_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_cnt <= CNT_W'(TURN_CYC);
            we_run  <= '0;
        end else begin
            if (!oe_n)                         rel_cnt <= '0;
            else if (rel_cnt < CNT_W'(TURN_CYC)) rel_cnt <= rel_cnt + 1'b1;
            if (!we_n) we_run <= we_run + 1'b1;
            else       we_run <= '0;
        end
    end

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    a_r7_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (rel_cnt >= CNT_W'(TURN_CYC)));

    a_r5_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> cs_on);

    a_r5_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run == (CNT_W+1)'(WR_CYC)));

    a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r9_valid_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ack);

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_RC_PS   = 100000,
    parameter int unsigned T_AA_PS   = 100000,
    parameter int unsigned T_OE_PS   = 50000,
    parameter int unsigned T_WC_PS   = 100000,
    parameter int unsigned T_WP_PS   = 70000,
    parameter int unsigned T_AW_PS   = 80000,
    parameter int unsigned T_DW_PS   = 40000,
    parameter int unsigned T_HZ_PS   = 30000,
    localparam int unsigned LANES    = 2,
    localparam int unsigned DATA_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_a,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_drv,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned RD_RAW  = umax(to_cycles(T_RC_PS, CLK_PS),
                                      umax(to_cycles(T_AA_PS, CLK_PS), to_cycles(T_OE_PS, CLK_PS)));
    localparam int unsigned WC_CYC  = to_cycles(T_WC_PS, CLK_PS);
    localparam int unsigned WR_RAW  = umax(umax(to_cycles(T_WP_PS, CLK_PS), to_cycles(T_AW_PS, CLK_PS)),
                                      umax(to_cycles(T_DW_PS, CLK_PS), (WC_CYC > 2) ? WC_CYC - 2 : 0));
    localparam int unsigned RD_CYC   = umax(RD_RAW, 1);
    localparam int unsigned WR_CYC   = umax(WR_RAW, 1);
    localparam int unsigned TURN_CYC = umax(to_cycles(T_HZ_PS, CLK_PS), 1);
    localparam int unsigned MAX_CYC  = umax(RD_CYC, umax(WR_CYC, TURN_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_last;
    logic             accept;
    logic             capture;
    logic             sel_nxt;
    logic             cs_on;
    logic [LANES-1:0] en_n;
    logic [ADDR_W-1:0] addr_q;

    sram_seq #(
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_mask_zero (req_be == '0),
        .timer_last    (timer_last),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .accept        (accept),
        .capture       (capture),
        .sel_nxt       (sel_nxt),
        .cs_on         (cs_on),
        .oe_n          (mem_oe_n),
        .we_n          (mem_we_n),
        .dq_oe         (mem_dq_drv),
        .ack           (req_ack),
        .rd_valid      (rd_valid)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .last     (timer_last)
    );

    sram_lane_io #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sel_nxt   (sel_nxt),
        .capture   (capture),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_i),
        .en_n      (en_n),
        .dq_out    (mem_dq_o),
        .rdata     (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    assign mem_a     = addr_q;
    assign mem_sel_n = !cs_on;
    assign mem_sel   = cs_on;
    assign mem_lo_n  = en_n[0];
    assign mem_hi_n  = en_n[1];

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_a));

    a_r6_lanes_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> ($stable(mem_lo_n) && $stable(mem_hi_n)));

    a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_drv && $past(mem_dq_drv)) |-> $stable(mem_dq_o));

endmodule

// File: tb/sim_sram_bridge.sv
module sim_sram_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_a;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_drv;
    logic [15:0] mem_dq_i;

    localparam int RD_LAT = 13;
    localparam int WR_LAT = 10;
    localparam int PULSE  = 8;
    localparam int GAP    = 3;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    bit  mon_on = 1'b0;
    bit  zero_mode = 1'b0;

    always #5 clk = ~clk;

    sram_bridge u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_ack(req_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_a(mem_a), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lo_n(mem_lo_n),
        .mem_hi_n(mem_hi_n), .mem_dq_o(mem_dq_o), .mem_dq_drv(mem_dq_drv),
        .mem_dq_i(mem_dq_i)
    );

    // Behavioural RAM on the pins and an independent expected memory
    logic [15:0] ram   [int];
    logic [15:0] exp_m [int];

    function automatic logic [15:0] dflt(input logic [17:0] a);
        return a[15:0] ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] ram_rd(input logic [17:0] a);
        if (ram.exists(int'(a))) return ram[int'(a)];
        return dflt(a);
    endfunction

    always @(posedge mem_we_n) begin
        if (mem_sel_n === 1'b0 && mem_sel === 1'b1) begin
            logic [15:0] w;
            w = ram_rd(mem_a);
            if (!mem_lo_n) w[7:0]  = mem_dq_drv ? mem_dq_o[7:0]  : 8'hxx;
            if (!mem_hi_n) w[15:8] = mem_dq_drv ? mem_dq_o[15:8] : 8'hxx;
            ram[int'(mem_a)] = w;
        end
    end

    always @(mem_a or mem_sel_n or mem_sel or mem_oe_n or mem_we_n or mem_lo_n or mem_hi_n) begin
        logic [15:0] v;
        v = ram_rd(mem_a);
        mem_dq_i = 16'hC3C3;
        if (mem_sel_n === 1'b0 && mem_sel === 1'b1 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
            if (!mem_lo_n) mem_dq_i[7:0]  = v[7:0];
            if (!mem_hi_n) mem_dq_i[15:8] = v[15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock protocol comparison
    int           we_low  = 0;
    int           rel     = 100;
    bit           prev_sel = 1'b0;
    bit           prev_ack = 1'b0;
    logic [17:0]  prev_a;
    logic [1:0]   prev_en;
    logic [15:0]  prev_d;

    always @(negedge clk) begin
        if (mon_on) begin
            bit sel;
            sel = (mem_sel_n == 1'b0) && (mem_sel == 1'b1);
            rel = mem_oe_n ? rel + 1 : 0;
            chk(!(mem_dq_drv && !mem_oe_n), "R7", "drivers on with output enable", 32'(mem_dq_drv), 0);
            chk(!(mem_dq_drv && rel >= 1 && rel <= GAP), "R7", "drivers inside release gap", 32'(rel), GAP + 1);
            chk(!(!mem_we_n && !sel), "R5", "strobe without select", 32'(sel), 1);
            chk(!(zero_mode && sel), "R8", "select on empty mask", 32'(sel), 0);
            chk(!(req_ack && prev_ack), "R9", "ack longer than one cycle", 2, 1);
            chk(!(rd_valid && !req_ack), "R9", "rd_valid without ack", 32'(req_ack), 1);
            if (!mem_we_n) begin
                we_low++;
            end else if (we_low != 0) begin
                chk(we_low == PULSE, "R5", "strobe pulse cycles", 32'(we_low), PULSE);
                we_low = 0;
            end
            if (sel && prev_sel) begin
                chk(mem_a == prev_a, "R6", "address moved while selected", 32'(mem_a), 32'(prev_a));
                chk({mem_hi_n, mem_lo_n} == prev_en, "R6", "lane enables moved", 32'({mem_hi_n, mem_lo_n}), 32'(prev_en));
                if (mem_dq_drv) chk(mem_dq_o == prev_d, "R6", "write data moved", 32'(mem_dq_o), 32'(prev_d));
            end
            prev_sel = sel;
            prev_ack = req_ack;
            prev_a   = mem_a;
            prev_en  = {mem_hi_n, mem_lo_n};
            prev_d   = mem_dq_o;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [17:0] a);
        if (exp_m.exists(int'(a))) return exp_m[int'(a)];
        return dflt(a);
    endfunction

    // One access; called at a negedge, returns at a negedge with the bridge idle
    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit scramble, input string req);
        int n;
        int lat;
        logic [15:0] expect_d;
        lat = (be == 2'b00) ? 0 : (wr ? WR_LAT : RD_LAT);
        zero_mode = (be == 2'b00);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        n = 0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (scramble && n == 0) begin
                req_addr = a ^ 18'h00101; req_wdata = ~d; req_be = ~be;
            end
            if (req_ack || n > 60) break;
            n++;
        end
        chk(n == lat, req, "ack latency in cycles", 32'(n), 32'(lat));
        expect_d = exp_rd(a);
        if (!wr && be != 2'b00) begin
            expect_d = {be[1] ? expect_d[15:8] : 8'h00, be[0] ? expect_d[7:0] : 8'h00};
            chk(rd_valid == 1'b1, req, "rd_valid with ack", 32'(rd_valid), 1);
            chk(rd_data == expect_d, req, "read data", 32'(rd_data), 32'(expect_d));
        end else begin
            chk(rd_valid == 1'b0, req, "no rd_valid", 32'(rd_valid), 0);
        end
        if (wr) begin
            if (be[0]) expect_d[7:0]  = d[7:0];
            if (be[1]) expect_d[15:8] = d[15:8];
            exp_m[int'(a)] = expect_d;
        end
        req_valid = 1'b0;
        @(negedge clk);
        zero_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_drv, req_ack, rd_valid}
            == 9'b101111000, "R1", "pins during reset",
            32'({mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_drv, req_ack, rd_valid}), 32'h178);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_drv, req_ack, rd_valid}
            == 9'b101111000, "R1", "pins idle after reset",
            32'({mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_drv, req_ack, rd_valid}), 32'h178);
        mon_on = 1'b1;

        access(1, 18'h00010, 16'hBEEF, 2'b11, 0, "R2_R5");  // full word write
        access(0, 18'h00010, 16'h0000, 2'b11, 0, "R2_R3");  // full word read
        access(1, 18'h00010, 16'h1234, 2'b01, 0, "R5");     // low lane only
        access(0, 18'h00010, 16'h0000, 2'b11, 0, "R5");     // expect BE34
        access(1, 18'h3FFFF, 16'hAB00, 2'b10, 0, "R5");     // top address, high lane
        access(0, 18'h3FFFF, 16'h0000, 2'b10, 0, "R4");     // low lane zeroed
        access(0, 18'h3FFFF, 16'h0000, 2'b01, 0, "R4");     // high lane zeroed
        access(1, 18'h00010, 16'h0000, 2'b00, 0, "R8");     // empty write mask
        access(0, 18'h00010, 16'h0000, 2'b00, 0, "R8");     // empty read mask
        access(0, 18'h00010, 16'h0000, 2'b11, 0, "R8");     // unchanged BE34
        access(1, 18'h00020, 16'h5A5A, 2'b11, 1, "R10");    // fields change mid-access
        access(0, 18'h00020, 16'h0000, 2'b11, 0, "R10");
        access(0, 18'h00121, 16'h0000, 2'b11, 1, "R10");    // untouched neighbour
        // read immediately followed by write, several lane patterns (R7)
        for (int i = 0; i < 8; i++) begin
            access(0, 18'(i * 37), 16'h0000, 2'(i % 3 + 1), 0, "R7");
            access(1, 18'(i * 37), 16'(i * 16'h1111 + 16'h0F0F), 2'(3 - i % 3), 0, "R7");
            access(0, 18'(i * 37), 16'h0000, 2'b11, 0, "R3");
        end
        mon_on = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule